// File: doc/BRIEF.md
# Byte-Wide Serial Peripheral Port with Master and Slave Roles

This block hangs off a small processor bus and moves one byte at a time over a four-wire synchronous serial link. Software programs a control byte to choose the role (driving the clock or following it), the clock idle level, which clock edge samples data, the master bit rate and whether the select pin is used. It then writes the data register to send a byte and reads the same address to fetch the byte that came back.

As master, the block divides the system clock to make SCK, shifts the byte out most significant bit first and samples the return line at the same time. As slave, it follows an externally supplied clock and active-low select, both passed through two-flop synchronizers. A transfer-complete flag and a mode-fault flag are ORed into a single interrupt request. A mode fault occurs when another device pulls the select pin low while this block is master.

Top module: `spi_port_ctrl`

## Requirements
- R1: After reset the control, status and data registers all read 0, and irq, sck_out, mosi_out and miso_out are all low.
- R2: The register map is: address 0 for control, address 1 for status, address 2 for data. Control bits, MSB to LSB, are rate[2], enable, ss_off, master, cpol, cpha, rate[1], rate[0], and a written control value reads back unchanged. The idle level of sck_out follows cpol (bit 3) at once.
- R3: As master, SCK runs at the system clock divided by 2^(rate+1), with rate 0..7. One byte takes 16 SCK edges, and the done flag sets exactly 16*2^rate clock edges after the edge that accepts the data write. SCK rests at cpol when idle.
- R4: A master transfer sends the written byte MSB first on mosi_out. Each bit is valid on the sampling edge: the edge away from idle when cpha=0, and the edge back to idle when cpha=1. The byte sampled from miso_in becomes the data register value.
- R5: With enable (bit 6) clear, a data write starts nothing: SCK does not toggle and the done flag stays clear.
- R6: Status bit 7 (done) sets when a byte completes. It clears only when a status read is followed by a data read or write. A data access without a prior status read leaves it set.
- R7: irq is high exactly when status bit 7 (done) or status bit 4 (fault) is set.
- R8: As master with ss_off clear, a low on ss_n_in sets status bit 4 (fault), clears the master bit, aborts the transfer and returns SCK to idle, all within 3 clock edges. A status read followed by a control write clears the fault.
- R9: With ss_off set, a master ignores ss_n_in and completes its byte normally.
- R10: As slave, while selected the block samples mosi_in on the cpha-selected sck_in edge. On miso_out it returns the byte previously written to the data register, MSB first. After the eighth sample it loads the received byte into the data register and sets done.
- R11: As slave, ss_off frees the select only when cpha=1. With cpha=0, a high ss_n_in still blocks reception even if ss_off is set.
- R12: A data write while a byte is in progress is dropped and sets status bit 6 (collision). The transfer in flight and its received byte are unaffected. Bit 6 clears with the same status-read-then-data-access sequence as bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | Write qualifier |
| bus_rd | input | 1 | Read qualifier (status and data reads have side effects) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| irq | output | 1 | Merged interrupt request |
| sck_out | output | 1 | Master serial clock |
| mosi_out | output | 1 | Master serial data out |
| miso_in | input | 1 | Master serial data in |
| sck_in | input | 1 | Slave serial clock |
| mosi_in | input | 1 | Slave serial data in |
| miso_out | output | 1 | Slave serial data out |
| ss_n_in | input | 1 | Active-low select pin |

## Verification
The master done flag is due exactly 16*2^rate edges after the edge that takes the data write. The bench checks that irq is still low one cycle before that edge and high right after it, for every rate and all four clock modes. Fault and slave completion pass through the two-flop synchronizers, so each shows up at most three edges after the pin change. The bench waits a fixed margin of four or more cycles before sampling. Pin values are read on falling clock edges, half a cycle away from any register update, and register reads are taken combinationally before the accepting edge.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

  typedef struct packed {
    logic       rate_hi;
    logic       en;
    logic       ss_off;
    logic       master;
    logic       cpol;
    logic       cpha;
    logic [1:0] rate_lo;
  } ctl_t;

  localparam logic [1:0] A_CTL  = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;

  function automatic logic [2:0] rate_code(ctl_t c);
    return {c.rate_hi, c.rate_lo};
  endfunction

  // system clocks per SCK half period
  function automatic int unsigned half_cycles(logic [2:0] code);
    return 32'd1 << code;
  endfunction

endpackage

// File: rtl/spi_rate_gen.sv
module spi_rate_gen
  import spi_port_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [2:0] code,
  output logic       tick
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  assign limit = CNT_W'(half_cycles(code) - 32'd1);
  assign tick  = run && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              sample,
  input  logic              drive,
  input  logic              ser_in,
  output logic [DATA_W-1:0] sreg,
  output logic              obit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg <= '0;
      obit <= 1'b0;
    end else if (load) begin
      sreg <= load_data;
      obit <= load_data[DATA_W-1];
    end else if (sample) begin
      sreg <= {sreg[DATA_W-2:0], ser_in};
    end else if (drive) begin
      obit <= sreg[DATA_W-1];
    end
  end
endmodule

// File: rtl/spi_port_ctrl.sv
module spi_port_ctrl
  import spi_port_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              sck_out,
  output logic              mosi_out,
  input  logic              miso_in,
  input  logic              sck_in,
  input  logic              mosi_in,
  output logic              miso_out,
  input  logic              ss_n_in
);
  localparam int EDGES = 2 * DATA_W;
  localparam int EC_W  = $clog2(EDGES + 1);
  localparam int BC_W  = $clog2(DATA_W + 1);

  ctl_t             ctl;
  logic [1:0]       sck_sync, ss_sync;
  logic             sck_prev;
  logic             m_busy, sck_phase;
  logic [EC_W-1:0]  edge_cnt;
  logic [BC_W-1:0]  bit_cnt;
  logic             spif, wcol, modf, armed;
  logic [DATA_W-1:0] rxbuf, sreg, rx_next;
  logic             obit;
  logic [7:0]       stat_byte;

  // bus decode
  logic wr_ctl, wr_data, rd_stat, rd_data;
  assign wr_ctl  = bus_sel && bus_wr && (bus_addr == A_CTL);
  assign wr_data = bus_sel && bus_wr && (bus_addr == A_DATA);
  assign rd_stat = bus_sel && bus_rd && (bus_addr == A_STAT);
  assign rd_data = bus_sel && bus_rd && (bus_addr == A_DATA);

  // named internal events
  logic ss_low, ss_honored, fault_evt, busy_any, load_evt, start_evt, wcol_evt;
  logic m_tick, m_leading, s_sel, s_edge, s_leading;
  logic edge_evt, lead_evt, sample_evt, drive_evt, ser_in, done_evt;
  logic clr_data, clr_ctl;

  assign ss_low     = !ss_sync[1];
  assign ss_honored = !ctl.ss_off || (!ctl.master && !ctl.cpha);
  assign fault_evt  = ctl.en && ctl.master && !ctl.ss_off && ss_low;
  assign busy_any   = m_busy || (bit_cnt != '0);
  assign load_evt   = wr_data && ctl.en && !busy_any && !fault_evt;
  assign start_evt  = load_evt && ctl.master;
  assign wcol_evt   = wr_data && busy_any;

  spi_rate_gen #(.CNT_W(CNT_W)) u_rate (
    .clk(clk), .rst_n(rst_n), .run(m_busy), .code(rate_code(ctl)), .tick(m_tick)
  );

  assign m_leading  = !edge_cnt[0];
  assign s_sel      = ctl.en && !ctl.master && (ss_low || !ss_honored);
  assign s_edge     = s_sel && (sck_sync[1] != sck_prev);
  assign s_leading  = (sck_sync[1] != ctl.cpol);
  assign edge_evt   = ctl.master ? m_tick : s_edge;
  assign lead_evt   = ctl.master ? m_leading : s_leading;
  assign sample_evt = edge_evt && (lead_evt != ctl.cpha);
  assign drive_evt  = edge_evt && (lead_evt == ctl.cpha);
  assign ser_in     = ctl.master ? miso_in : mosi_in;
  assign done_evt   = !fault_evt && (ctl.master
                      ? (m_tick && (edge_cnt == EC_W'(EDGES - 1)))
                      : (sample_evt && (bit_cnt == BC_W'(DATA_W - 1))));
  assign rx_next    = sample_evt ? {sreg[DATA_W-2:0], ser_in} : sreg;
  assign clr_data   = armed && (wr_data || rd_data);
  assign clr_ctl    = armed && wr_ctl;

  spi_shift_core #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load_evt), .load_data(bus_wdata),
    .sample(sample_evt), .drive(drive_evt), .ser_in(ser_in),
    .sreg(sreg), .obit(obit)
  );

  // pin synchronizers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sync <= 2'b00;
      sck_prev <= 1'b0;
      ss_sync  <= 2'b11;
    end else begin
      sck_sync <= {sck_sync[0], sck_in};
      sck_prev <= sck_sync[1];
      ss_sync  <= {ss_sync[0], ss_n_in};
    end
  end

  // control register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl <= '0;
    else begin
      if (wr_ctl)    ctl <= ctl_t'(bus_wdata[7:0]);
      if (fault_evt) ctl.master <= 1'b0;
    end
  end

  // master sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 1'b0; edge_cnt <= '0; sck_phase <= 1'b0;
    end else if (!ctl.en || fault_evt) begin
      m_busy <= 1'b0; edge_cnt <= '0; sck_phase <= 1'b0;
    end else if (start_evt) begin
      m_busy <= 1'b1; edge_cnt <= '0; sck_phase <= 1'b0;
    end else if (m_busy && m_tick) begin
      edge_cnt  <= edge_cnt + 1'b1;
      sck_phase <= !sck_phase;
      if (done_evt) m_busy <= 1'b0;
    end
  end

  // slave bit counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bit_cnt <= '0;
    else if (ctl.master || !ctl.en || (ss_honored && !ss_low)) bit_cnt <= '0;
    else if (sample_evt) bit_cnt <= done_evt ? '0 : bit_cnt + 1'b1;
  end

  // flags and receive buffer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0; spif <= 1'b0; wcol <= 1'b0; modf <= 1'b0; rxbuf <= '0;
    end else begin
      if (rd_stat) armed <= 1'b1;
      else if (wr_data || rd_data || wr_ctl) armed <= 1'b0;
      if (done_evt) spif <= 1'b1;
      else if (clr_data) spif <= 1'b0;
      if (wcol_evt) wcol <= 1'b1;
      else if (clr_data) wcol <= 1'b0;
      if (fault_evt) modf <= 1'b1;
      else if (clr_ctl) modf <= 1'b0;
      if (done_evt) rxbuf <= rx_next;
    end
  end

  assign stat_byte = {spif, wcol, 1'b0, modf, 4'b0000};

  always_comb begin
    case (bus_addr)
      A_CTL:   bus_rdata = DATA_W'(ctl);
      A_STAT:  bus_rdata = DATA_W'(stat_byte);
      A_DATA:  bus_rdata = rxbuf;
      default: bus_rdata = '0;
    endcase
  end

  assign irq      = spif || modf;
  assign sck_out  = ctl.cpol ^ sck_phase;
  assign mosi_out = ctl.master && obit;
  assign miso_out = !ctl.master && obit;
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk (
  input logic clk,
  input logic rst_n,
  input logic irq,
  input logic sck_out,
  input logic cpol,
  input logic en,
  input logic master,
  input logic m_busy,
  input logic done_evt,
  input logic fault_evt,
  input logic wcol_evt,
  input logic spif,
  input logic wcol,
  input logic modf
);
  // R7: a new request comes only from a completion or a fault
  a_r7_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(done_evt || fault_evt));

  // R3: SCK rests at its idle level whenever no master byte runs
  a_r3_sck_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !m_busy |-> (sck_out == cpol));

  // R8: fault demotes to slave and stops the transfer
  a_r8_fault_demotes: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |=> (!master && !m_busy && modf));

  // R6: completion raises the done flag
  a_r6_done_flag: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> spif);

  // R12: a colliding write raises the collision flag
  a_r12_collision: assert property (@(posedge clk) disable iff (!rst_n)
    wcol_evt |=> wcol);

  // R5: disabled block holds no master transfer
  a_r5_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !m_busy);
endmodule

bind spi_port_ctrl spi_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .sck_out(sck_out),
  .cpol(ctl.cpol), .en(ctl.en), .master(ctl.master), .m_busy(m_busy),
  .done_evt(done_evt), .fault_evt(fault_evt), .wcol_evt(wcol_evt),
  .spif(spif), .wcol(wcol), .modf(modf)
);

// File: tb/tb_spi_port_ctrl.sv
`timescale 1ns/1ps
module tb_spi_port_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 0, bus_wr = 0, bus_rd = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic irq, sck_out, mosi_out, miso_in, miso_out;
  logic sck_in = 0, mosi_in = 0, ss_n_in = 1;
  int checks = 0, fails = 0;

  // monitor state
  logic sck_last = 0, mon_cpol = 0, mon_cpha = 0;
  int toggles = 0;
  logic [7:0] cap = 0;

  assign miso_in = mosi_out;  // master loopback

  spi_port_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .sck_out(sck_out), .mosi_out(mosi_out), .miso_in(miso_in), .sck_in(sck_in),
    .mosi_in(mosi_in), .miso_out(miso_out), .ss_n_in(ss_n_in)
  );

  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (sck_out !== sck_last) begin
      toggles++;
      if ((sck_out != mon_cpol) != mon_cpha) cap = {cap[6:0], mosi_out};
    end
    sck_last = sck_out;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_rd = 1; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_sel = 0; bus_rd = 0;
  endtask

  task automatic half_wait();
    repeat (8) @(negedge clk);
  endtask

  task automatic master_run(input int rate, input logic cpol, input logic cpha, input logic [7:0] tx);
    logic [7:0] v;
    int h;
    h = 1 << rate;
    bus_write(2'd0, {rate[2], 1'b1, 1'b1, 1'b1, cpol, cpha, rate[1:0]});
    mon_cpol = cpol; mon_cpha = cpha;
    @(negedge clk); #1 toggles = 0; cap = 0;
    bus_write(2'd2, tx);
    repeat (16 * h - 1) @(posedge clk);
    @(negedge clk); chk("R3 done not before 16*2^rate", irq, 0);
    @(posedge clk); @(negedge clk); chk("R3 done at 16*2^rate", irq, 1);
    @(negedge clk);
    chk("R3 sck edge count", toggles, 16);
    chk("R3 sck idles at cpol", sck_out, cpol);
    chk("R4 msb-first bits on sampling edges", cap, tx);
    bus_read(2'd1, v); chk("R6 done bit set", v, 8'h80);
    bus_read(2'd2, v); chk("R4 received byte", v, tx);
    bus_read(2'd1, v); chk("R6 cleared by status then data", v, 8'h00);
    chk("R7 irq follows flags", irq, 0);
  endtask

  task automatic slave_run(input logic cpol, input logic cpha, input logic ss_off, input logic drop_ss,
                           input logic [7:0] dut_byte, input logic [7:0] ext_byte, output logic [7:0] got);
    got = '0;
    sck_in = cpol; ss_n_in = 1; mosi_in = 0;
    repeat (4) @(negedge clk);
    bus_write(2'd0, {1'b0, 1'b1, ss_off, 1'b0, cpol, cpha, 2'b00});
    bus_write(2'd2, dut_byte);
    @(negedge clk);
    if (drop_ss) ss_n_in = 0;
    if (!cpha) mosi_in = ext_byte[7];
    half_wait();
    for (int i = 7; i >= 0; i--) begin
      sck_in = !cpol;
      if (cpha) mosi_in = ext_byte[i];
      else got = {got[6:0], miso_out};
      half_wait();
      sck_in = cpol;
      if (cpha) got = {got[6:0], miso_out};
      else if (i > 0) mosi_in = ext_byte[i-1];
      half_wait();
    end
    ss_n_in = 1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v, got, last_rx;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    bus_read(2'd0, v); chk("R1 control reset", v, 0);
    bus_read(2'd1, v); chk("R1 status reset", v, 0);
    bus_read(2'd2, v); chk("R1 data reset", v, 0);
    chk("R1 irq low", irq, 0);
    chk("R1 sck low", sck_out, 0);
    chk("R1 serial outs low", {mosi_out, miso_out}, 0);

    // R2 layout
    bus_write(2'd0, 8'hA5);
    bus_read(2'd0, v); chk("R2 control readback", v, 8'hA5);
    bus_write(2'd0, 8'h5A);
    bus_read(2'd0, v); chk("R2 control readback", v, 8'h5A);
    @(negedge clk); chk("R2 cpol bit drives idle sck", sck_out, 1);
    bus_write(2'd0, 8'h00);

    // R5 disabled
    bus_write(2'd0, 8'h30);
    @(negedge clk); #1 toggles = 0;
    bus_write(2'd2, 8'h77);
    repeat (40) @(negedge clk);
    chk("R5 no sck while disabled", toggles, 0);
    chk("R5 no irq while disabled", irq, 0);
    bus_read(2'd1, v); chk("R5 no done while disabled", v, 0);

    // R3/R4/R6/R7 master sweep
    for (int r = 0; r < 8; r++)
      for (int m = 0; m < 4; m++)
        master_run(r, m[1], m[0], 8'(8'h5B + r * 29 + m * 71));

    // R6 data access without status read keeps flag
    master_run(0, 0, 0, 8'h81);
    bus_write(2'd2, 8'h42);
    repeat (40) @(negedge clk);
    bus_read(2'd2, v);
    bus_read(2'd1, v); chk("R6 data access alone keeps done", v, 8'h80);
    bus_read(2'd2, v); chk("R4 second byte received", v, 8'h42);
    bus_read(2'd1, v); chk("R6 cleared after sequence", v, 0);

    // R12 collision
    bus_write(2'd0, 8'h71);
    bus_write(2'd2, 8'hE1);
    bus_write(2'd2, 8'h1E);
    repeat (60) @(negedge clk);
    bus_read(2'd1, v); chk("R12 collision and done bits", v, 8'hC0);
    bus_read(2'd2, v); chk("R12 first byte kept", v, 8'hE1);
    bus_read(2'd1, v); chk("R12 collision cleared", v, 0);

    // R9 select ignored by master when ss_off set
    ss_n_in = 0;
    bus_write(2'd0, 8'h70);
    bus_write(2'd2, 8'h96);
    repeat (30) @(negedge clk);
    bus_read(2'd1, v); chk("R9 completes without fault", v, 8'h80);
    bus_read(2'd2, v); chk("R9 byte received", v, 8'h96);
    ss_n_in = 1;
    repeat (4) @(negedge clk);

    // R8 mode fault
    bus_write(2'd0, 8'h53);
    bus_write(2'd2, 8'h5A);
    repeat (10) @(negedge clk);
    ss_n_in = 0;
    repeat (4) @(negedge clk);
    chk("R8 fault raises irq", irq, 1);
    chk("R8 sck back to idle", sck_out, 0);
    bus_read(2'd1, v); chk("R8 fault bit", v, 8'h10);
    bus_read(2'd0, v); chk("R8 master bit cleared", v, 8'h43);
    repeat (40) @(negedge clk);
    bus_read(2'd1, v); chk("R8 aborted byte never completes", v, 8'h10);
    ss_n_in = 1;
    repeat (4) @(negedge clk);
    bus_read(2'd1, v);
    bus_write(2'd0, 8'h53);
    @(negedge clk); chk("R8 fault cleared by status then control", irq, 0);
    bus_read(2'd1, v); chk("R8 status clear", v, 0);

    // R10 slave sweep
    for (int m = 0; m < 4; m++) begin
      logic [7:0] db, eb;
      db = 8'(8'h3C + m * 53);
      eb = 8'(8'hC5 ^ (m * 91));
      slave_run(m[1], m[0], 1'b0, 1'b1, db, eb, got);
      chk("R10 slave returns written byte", got, db);
      chk("R7 slave completion irq", irq, 1);
      bus_read(2'd1, v); chk("R10 slave done bit", v, 8'h80);
      bus_read(2'd2, v); chk("R10 slave received byte", v, eb);
      last_rx = eb;
    end

    // R11 select disable rule for slave
    slave_run(1'b0, 1'b0, 1'b1, 1'b0, 8'h11, 8'hEE, got);
    chk("R11 cpha0 select still required", irq, 0);
    bus_read(2'd2, v); chk("R11 data unchanged", v, last_rx);
    slave_run(1'b0, 1'b1, 1'b1, 1'b0, 8'h22, 8'hD4, got);
    chk("R11 cpha1 select freed", irq, 1);
    bus_read(2'd1, v);
    bus_read(2'd2, v); chk("R11 cpha1 byte received", v, 8'hD4);
    chk("R11 slave byte returned", got, 8'h22);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule